// File: doc/BRIEF.md
# Demand-Actuated Junction Signal Controller

The block runs the signals at the crossing of a main road and a side road. Each road has a red, a yellow and a green lamp and a two-digit countdown value. The controller steps through four phases in a fixed ring: main green, main yellow, side green, side yellow. How long it stays in each green phase depends on two vehicle-present sensors. The main road keeps green until the side road has a car waiting. A green phase is shortened or held open depending on which roads have traffic.

Time is measured in ticks. A tick is a one-clock strobe produced upstream, nominally once per second. Each countdown value is packed BCD and shows the ticks left until that road's lamps next change. For the road on red, this count includes the other road's yellow time. When a green phase is held open by the sensors, there is no change point to count towards, so both displays read 00. Seven-segment decoding, clock division and sensor debouncing are done outside the block.

Top module: `traffic_ctrl`

## Requirements
- R1: After reset the controller is in main green (main green lamp on, side red lamp on) with the phase timer cleared. With no vehicles present, both displays read 8'h00.
- R2: In every cycle exactly one of red, yellow and green is lit on each road.
- R3: Phases change only in the ring main green, main yellow, side green, side yellow, then back to main green. The lamps in each phase are:
  - main green: main green, side red.
  - main yellow: main yellow, side red.
  - side green: main red, side green.
  - side yellow: main red, side yellow.
- R4: In main green, while the side sensor is low, the controller stays in main green and both displays read 8'h00.
- R5: In main green with both sensors high, the phase lasts MAIN_GREEN_S ticks (default 45). The main display counts 45 down to 1 and the side display counts 50 down to 6.
- R6: In main green with the side sensor high and the main sensor low, the next clock enters main yellow without waiting for the timer.
- R7: Each yellow phase lasts YELLOW_S ticks (default 5). During it, both displays count 5 down to 1.
- R8: In side green with both sensors high, the phase lasts SIDE_GREEN_S ticks (default 25). The side display counts 25 down to 1 and the main display counts 30 down to 6.
- R9: In side green, a low side sensor moves the controller into side yellow on the next clock.
- R10: In side green with the side sensor high and the main sensor low, side green is held and both displays read 8'h00.
- R11: The phase timer advances only on clocks where tick_i is high. It restarts from zero at every phase change and whenever a green phase is held open. Without ticks, a yellow phase and its displays do not change.
- R12: Displays are packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock timing strobe (one per second) |
| main_car_i | input | 1 | Vehicle present on the main road |
| side_car_i | input | 1 | Vehicle present on the side road |
| main_red_o | output | 1 | Main road red lamp |
| main_yel_o | output | 1 | Main road yellow lamp |
| main_grn_o | output | 1 | Main road green lamp |
| side_red_o | output | 1 | Side road red lamp |
| side_yel_o | output | 1 | Side road yellow lamp |
| side_grn_o | output | 1 | Side road green lamp |
| main_cnt_o | output | 8 | Main road countdown, packed BCD |
| side_cnt_o | output | 8 | Side road countdown, packed BCD |

## Verification
The bench first leaves both sensors low, which shows resting in main green apart from any timed cycle. With both sensors high, it runs the full timed ring, which checks every phase length and both countdown offsets. A drop of the main sensor in the middle of main green separates the early cut from the timed exit. In side green, a side-only pattern and then a side drop separate holding from early release. Pausing the tick stream inside a yellow phase shows that the timer advances on ticks and not on clocks.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_e;

  // saturates at 99
  function automatic logic [7:0] to_bcd(input int unsigned v);
    int unsigned c;
    c = (v > 99) ? 99 : v;
    return {4'(c / 10), 4'(c % 10)};
  endfunction
endpackage

// File: rtl/tl_timer.sv
module tl_timer #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (tick_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_pkg::*;
#(
  parameter int unsigned MAIN_GREEN_S = 45,
  parameter int unsigned SIDE_GREEN_S = 25,
  parameter int unsigned YELLOW_S     = 5,
  parameter int unsigned W            = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         main_car_i,
  input  logic         side_car_i,
  input  logic [W-1:0] cnt_i,
  output phase_e       phase_o,
  output logic         timed_o,
  output logic         clr_o
);
  phase_e phase_q, phase_d;
  logic   adv;
  logic   end_main, end_side, end_yel;
  logic   both;

  assign both     = main_car_i & side_car_i;
  assign end_main = tick_i && (32'(cnt_i) == MAIN_GREEN_S - 1);
  assign end_side = tick_i && (32'(cnt_i) == SIDE_GREEN_S - 1);
  assign end_yel  = tick_i && (32'(cnt_i) == YELLOW_S - 1);

  always_comb begin
    timed_o = 1'b1;
    adv     = 1'b0;
    phase_d = phase_q;
    unique case (phase_q)
      PH_MAIN_GO: begin
        timed_o = both;
        adv     = (side_car_i & ~main_car_i) | (both & end_main);
        if (adv) phase_d = PH_MAIN_WARN;
      end
      PH_MAIN_WARN: begin
        adv = end_yel;
        if (adv) phase_d = PH_SIDE_GO;
      end
      PH_SIDE_GO: begin
        timed_o = both;
        adv     = ~side_car_i | (both & end_side);
        if (adv) phase_d = PH_SIDE_WARN;
      end
      PH_SIDE_WARN: begin
        adv = end_yel;
        if (adv) phase_d = PH_MAIN_GO;
      end
      default: phase_d = PH_MAIN_GO;
    endcase
  end

  // held greens keep the timer at zero
  assign clr_o = adv | ~timed_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_MAIN_GO;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tl_display.sv
module tl_display
  import tl_pkg::*;
#(
  parameter int unsigned MAIN_GREEN_S = 45,
  parameter int unsigned SIDE_GREEN_S = 25,
  parameter int unsigned YELLOW_S     = 5,
  parameter int unsigned W            = 6
) (
  input  phase_e       phase_i,
  input  logic [W-1:0] cnt_i,
  input  logic         timed_i,
  output logic [7:0]   main_bcd_o,
  output logic [7:0]   side_bcd_o
);
  int unsigned c, rem_m, rem_s;

  always_comb begin
    c = 32'(cnt_i);
    unique case (phase_i)
      PH_MAIN_GO: begin
        rem_m = MAIN_GREEN_S - c;
        rem_s = MAIN_GREEN_S + YELLOW_S - c;
      end
      PH_SIDE_GO: begin
        rem_m = SIDE_GREEN_S + YELLOW_S - c;
        rem_s = SIDE_GREEN_S - c;
      end
      default: begin
        rem_m = YELLOW_S - c;
        rem_s = YELLOW_S - c;
      end
    endcase
    if (!timed_i) begin
      rem_m = 0;
      rem_s = 0;
    end
    main_bcd_o = to_bcd(rem_m);
    side_bcd_o = to_bcd(rem_s);
  end
endmodule

// File: rtl/traffic_ctrl.sv
module traffic_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned MAIN_GREEN_S = 45,
  parameter int unsigned SIDE_GREEN_S = 25,
  parameter int unsigned YELLOW_S     = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       main_car_i,
  input  logic       side_car_i,
  output logic       main_red_o,
  output logic       main_yel_o,
  output logic       main_grn_o,
  output logic       side_red_o,
  output logic       side_yel_o,
  output logic       side_grn_o,
  output logic [7:0] main_cnt_o,
  output logic [7:0] side_cnt_o
);
  localparam int unsigned LONGEST = (MAIN_GREEN_S > SIDE_GREEN_S) ?
                                    MAIN_GREEN_S : SIDE_GREEN_S;
  localparam int unsigned CW = $clog2(LONGEST + YELLOW_S + 1);

  phase_e        phase;
  logic          timed, clr;
  logic [CW-1:0] cnt;

  tl_timer #(.W(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  tl_phase_fsm #(
    .MAIN_GREEN_S(MAIN_GREEN_S), .SIDE_GREEN_S(SIDE_GREEN_S),
    .YELLOW_S(YELLOW_S), .W(CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .main_car_i (main_car_i),
    .side_car_i (side_car_i),
    .cnt_i      (cnt),
    .phase_o    (phase),
    .timed_o    (timed),
    .clr_o      (clr)
  );

  tl_display #(
    .MAIN_GREEN_S(MAIN_GREEN_S), .SIDE_GREEN_S(SIDE_GREEN_S),
    .YELLOW_S(YELLOW_S), .W(CW)
  ) u_disp (
    .phase_i    (phase),
    .cnt_i      (cnt),
    .timed_i    (timed),
    .main_bcd_o (main_cnt_o),
    .side_bcd_o (side_cnt_o)
  );

  always_comb begin
    {main_red_o, main_yel_o, main_grn_o} = 3'b100;
    {side_red_o, side_yel_o, side_grn_o} = 3'b100;
    unique case (phase)
      PH_MAIN_GO:   {main_red_o, main_yel_o, main_grn_o} = 3'b001;
      PH_MAIN_WARN: {main_red_o, main_yel_o, main_grn_o} = 3'b010;
      PH_SIDE_GO:   {side_red_o, side_yel_o, side_grn_o} = 3'b001;
      PH_SIDE_WARN: {side_red_o, side_yel_o, side_grn_o} = 3'b010;
      default: ;
    endcase
  end
endmodule

// File: rtl/tl_checker.sv
module tl_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       main_car_i,
  input logic       side_car_i,
  input logic       main_red_o,
  input logic       main_yel_o,
  input logic       main_grn_o,
  input logic       side_red_o,
  input logic       side_yel_o,
  input logic       side_grn_o,
  input logic [7:0] main_cnt_o,
  input logic [7:0] side_cnt_o
);
  assert_main_lamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({main_red_o, main_yel_o, main_grn_o}) == 1);
  assert_side_lamp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({side_red_o, side_yel_o, side_grn_o}) == 1);

  assert_ring_mg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_grn_o |=> main_grn_o || main_yel_o);
  assert_ring_my_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_yel_o |=> main_yel_o || side_grn_o);
  assert_ring_sg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_grn_o |=> side_grn_o || side_yel_o);
  assert_ring_sy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_yel_o |=> side_yel_o || main_grn_o);

  assert_rest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_grn_o && !side_car_i |=> main_grn_o);
  assert_rest_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_grn_o && !side_car_i |-> main_cnt_o == 8'h00 && side_cnt_o == 8'h00);

  assert_cut_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_grn_o && side_car_i && !main_car_i |=> main_yel_o);

  assert_yel_equal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_yel_o) |-> main_cnt_o == side_cnt_o);

  assert_side_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_grn_o && !side_car_i |=> side_yel_o);

  assert_side_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side_grn_o && side_car_i && !main_car_i |=> side_grn_o);

  assert_tick_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_yel_o && !tick_i |=> main_yel_o && $stable(main_cnt_o));
endmodule

bind traffic_ctrl tl_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .main_car_i (main_car_i),
  .side_car_i (side_car_i),
  .main_red_o (main_red_o),
  .main_yel_o (main_yel_o),
  .main_grn_o (main_grn_o),
  .side_red_o (side_red_o),
  .side_yel_o (side_yel_o),
  .side_grn_o (side_grn_o),
  .main_cnt_o (main_cnt_o),
  .side_cnt_o (side_cnt_o)
);

// File: tb/sim_traffic_ctrl.sv
`timescale 1ns/1ps
module sim_traffic_ctrl;
  localparam int MG = 45, SG = 25, YL = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic main_car_i = 1'b0, side_car_i = 1'b0;
  logic main_red_o, main_yel_o, main_grn_o, side_red_o, side_yel_o, side_grn_o;
  logic [7:0] main_cnt_o, side_cnt_o;

  int n_run = 0, n_fail = 0;
  bit tick_en = 1'b1, done = 1'b0;
  int div = 0;
  int m_ph = 0, m_t = 0;   // reference: phase 0..3, ticks in phase

  traffic_ctrl u0 (.*);

  always #2.5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    div = (div + 1) % 4;
    #1 tick_i = tick_en && (div == 3);
  end

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_t = 0;
    end else begin
      bit both, nxt;
      int len;
      both = main_car_i && side_car_i;
      nxt = 0;
      len = (m_ph == 0) ? MG : (m_ph == 2) ? SG : YL;
      if (m_ph == 0 && side_car_i && !main_car_i) nxt = 1;
      else if (m_ph == 2 && !side_car_i) nxt = 1;
      else if ((m_ph == 0 || m_ph == 2) && !both) m_t = 0;
      else if (tick_i) begin
        if (m_t == len - 1) nxt = 1;
        else m_t++;
      end
      if (nxt) begin
        m_ph = (m_ph + 1) % 4; m_t = 0;
      end
    end
  end

  // per-clock compare
  always @(negedge clk_i) begin
    logic [2:0] ml, sl;
    int em, es;
    string rq;
    bit held;
    held = (m_ph == 0 || m_ph == 2) && !(main_car_i && side_car_i);
    case (m_ph)
      0: begin ml = 3'b001; sl = 3'b100; em = MG - m_t; es = MG + YL - m_t; rq = "R5"; end
      1: begin ml = 3'b010; sl = 3'b100; em = YL - m_t; es = YL - m_t; rq = "R7"; end
      2: begin ml = 3'b100; sl = 3'b001; em = SG + YL - m_t; es = SG - m_t; rq = "R8"; end
      default: begin ml = 3'b100; sl = 3'b010; em = YL - m_t; es = YL - m_t; rq = "R7"; end
    endcase
    if (held) begin em = 0; es = 0; rq = (m_ph == 0) ? "R4" : "R10"; end
    if (!done) begin
      chk({main_red_o, main_yel_o, main_grn_o} == ml, "R3 main lamps", {5'd0, main_red_o, main_yel_o, main_grn_o}, {5'd0, ml});
      chk({side_red_o, side_yel_o, side_grn_o} == sl, "R3 side lamps", {5'd0, side_red_o, side_yel_o, side_grn_o}, {5'd0, sl});
      chk(main_cnt_o == bcd(em), {rq, " main count"}, main_cnt_o, bcd(em));
      chk(side_cnt_o == bcd(es), {rq, " side count"}, side_cnt_o, bcd(es));
    end
  end

  task automatic wait_lamp(input int which);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if ((which == 0 && main_grn_o) || (which == 1 && main_yel_o) ||
          (which == 2 && side_grn_o) || (which == 3 && side_yel_o)) return;
    end
    chk(1'b0, "R3 phase not reached", 8'd0, 8'(which));
  endtask

  task automatic drive(input bit mc, input bit sc);
    @(negedge clk_i);
    #1 main_car_i = mc; side_car_i = sc;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100_000);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_up();
  end

  initial begin
    logic [7:0] held_cnt;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(main_grn_o && side_red_o, "R1 lamps", {6'd0, main_grn_o, side_red_o}, 8'h03);
    chk(main_cnt_o == 8'h00 && side_cnt_o == 8'h00, "R1 counts", main_cnt_o, 8'h00);
    // R4 rest
    repeat (40) @(negedge clk_i);
    chk(main_grn_o == 1'b1, "R4 rest", {7'd0, main_grn_o}, 8'h01);
    drive(1'b1, 1'b0);
    repeat (20) @(negedge clk_i);
    chk(main_grn_o && main_cnt_o == 8'h00, "R4 main only", main_cnt_o, 8'h00);
    // timed ring, R5 R12
    drive(1'b1, 1'b1);
    @(negedge clk_i);
    chk(main_cnt_o == 8'h45, "R12 main bcd", main_cnt_o, 8'h45);
    chk(side_cnt_o == 8'h50, "R5 side start", side_cnt_o, 8'h50);
    wait_lamp(1);
    chk(main_cnt_o == 8'h05 && side_cnt_o == 8'h05, "R7 yellow start", main_cnt_o, 8'h05);
    wait_lamp(2);
    chk(side_cnt_o == 8'h25, "R8 side start", side_cnt_o, 8'h25);
    chk(main_cnt_o == 8'h30, "R8 main start", main_cnt_o, 8'h30);
    wait_lamp(3);
    wait_lamp(0);
    chk(main_cnt_o == 8'h45, "R3 ring back", main_cnt_o, 8'h45);
    // R6 early cut
    repeat (40) @(negedge clk_i);
    drive(1'b0, 1'b1);
    @(negedge clk_i);
    chk(main_yel_o == 1'b1, "R6 cut", {7'd0, main_yel_o}, 8'h01);
    // R11 ticks paused in yellow
    #1 tick_en = 1'b0;
    @(negedge clk_i);
    held_cnt = main_cnt_o;
    repeat (30) @(negedge clk_i);
    chk(main_yel_o && main_cnt_o == held_cnt, "R11 no tick", main_cnt_o, held_cnt);
    #1 tick_en = 1'b1;
    // R10 hold side green
    wait_lamp(2);
    repeat (60) @(negedge clk_i);
    chk(side_grn_o == 1'b1, "R10 hold", {7'd0, side_grn_o}, 8'h01);
    chk(side_cnt_o == 8'h00 && main_cnt_o == 8'h00, "R10 blank", side_cnt_o, 8'h00);
    // R9 side drop
    drive(1'b0, 1'b0);
    @(negedge clk_i);
    chk(side_yel_o == 1'b1, "R9 drop", {7'd0, side_yel_o}, 8'h01);
    wait_lamp(0);
    repeat (30) @(negedge clk_i);
    chk(main_grn_o == 1'b1, "R4 rest again", {7'd0, main_grn_o}, 8'h01);
    chk($countones({side_red_o, side_yel_o, side_grn_o}) == 1, "R2 one lamp",
        {5'd0, side_red_o, side_yel_o, side_grn_o}, 8'h04);
    finish_up();
  end
endmodule